// File: doc/BRIEF.md
# Iterative Integer Divider with Sign Handling

This block performs integer division and remainder for a 64-bit processor pipeline. It covers signed and unsigned division, signed and unsigned remainder, and the 32-bit word forms of all four. The caller pulses `start_i` with the operation code and both operands. `busy_o` stays high while the work is in progress. `done_o` pulses with the 64-bit result on `result_o`. The result stays on `result_o` until the next accepted start.

Internally an unsigned restoring shift-subtract engine produces one quotient bit per clock. Signed operands are first reduced to unsigned magnitudes. After the last step, the signs are put back on the quotient and the remainder. A zero divisor and the single signed overflow case never reach the engine. They are resolved in one cycle with their architectural results. Word-form results are always sign-extended from bit 31.

Top module: `div_unit`

## Requirements
- R1: `op_i` selects the operation: bit 1 = 1 returns the remainder, 0 returns the quotient; bit 0 = 1 treats operands as unsigned, 0 as two's-complement signed (00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder). `word_i` = 1 selects the 32-bit form.
- R2: A start accepted while `busy_o` is low with a nonzero divisor and no overflow raises `busy_o` from the next cycle on. `done_o` rises 65 cycles after the start cycle for full-width operations and 33 cycles after it for word forms. `busy_o` drops in the same cycle.
- R3: `done_o` is high for one cycle per operation. From that cycle until the next accepted start, `result_o` holds the result. A start is accepted in the done cycle itself.
- R4: `start_i` is ignored while `busy_o` is high. The running operation completes with its original operands and timing.
- R5: Unsigned quotient and remainder satisfy dividend = quotient × divisor + remainder, with remainder < divisor.
- R6: The signed quotient truncates toward zero: its magnitude is the magnitude quotient, negated when the operand signs differ. The signed remainder carries the sign of the dividend.
- R7: A zero divisor gives an all-ones quotient and a remainder equal to the dividend. `done_o` rises in the cycle after the start, and `busy_o` stays low.
- R8: The most negative dividend divided by -1 (signed forms only) gives the dividend as the quotient and zero as the remainder, with the same one-cycle timing as R7.
- R9: Word forms use only bits 31:0 of each operand. The result is bit 31 replicated into bits 63:32, for the unsigned word forms as well.
- R10: While reset is asserted and after it is released, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 2 | Operation code, encoding in R1 |
| word_i | input | 1 | Select 32-bit word form |
| dividend_i | input | 64 | Dividend operand |
| divisor_i | input | 64 | Divisor operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 64 | Quotient or remainder |

## Verification
The bench aims at both shortcut paths: zero divisors in every form, and the most negative dividend over -1 at both widths. A design that sent these through the engine would come back 33 or 65 cycles late, or with a wrapped remainder. Mixed-sign operands test sign restoration. A dividend-signed remainder rule applied to the divisor instead would flip results such as 100 rem -7. Word operands carry garbage in bits 63:32, and unsigned word results have bit 31 set. These expose a design that reads the upper halves or zero-extends the result. Finally, a start pulse in mid-operation and a start in the done cycle check that the first is dropped and the second is taken.

// File: rtl/div_pkg.sv
package div_pkg;
    // bit positions inside the operation code
    localparam int OPB_UNS = 0;  // 1: unsigned operands
    localparam int OPB_REM = 1;  // 1: return remainder
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: width selection, sign capture, magnitudes and
// detection of the two cases resolved without iterating.
module div_prep
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] dvd_i,
    input  logic [XLEN-1:0] dvs_i,
    output logic [XLEN-1:0] mag_a_o,
    output logic [XLEN-1:0] mag_b_o,
    output logic            neg_q_o,
    output logic            neg_r_o,
    output logic            spec_o,
    output logic [XLEN-1:0] spec_val_o
);
    localparam int HALF = XLEN / 2;

    logic            sgn;
    logic [XLEN-1:0] ext_a, ext_b, min_val;
    logic            neg_a, neg_b, zero_div, ovf;

    always_comb begin
        sgn = ~op_i[OPB_UNS];
        if (word_i) begin
            ext_a = sgn ? {{HALF{dvd_i[HALF-1]}}, dvd_i[HALF-1:0]}
                        : {{HALF{1'b0}}, dvd_i[HALF-1:0]};
            ext_b = sgn ? {{HALF{dvs_i[HALF-1]}}, dvs_i[HALF-1:0]}
                        : {{HALF{1'b0}}, dvs_i[HALF-1:0]};
            min_val = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
        end else begin
            ext_a   = dvd_i;
            ext_b   = dvs_i;
            min_val = {1'b1, {(XLEN-1){1'b0}}};
        end
        neg_a    = sgn & ext_a[XLEN-1];
        neg_b    = sgn & ext_b[XLEN-1];
        mag_a_o  = neg_a ? (~ext_a + 1'b1) : ext_a;
        mag_b_o  = neg_b ? (~ext_b + 1'b1) : ext_b;
        neg_q_o  = neg_a ^ neg_b;
        neg_r_o  = neg_a;
        zero_div = (ext_b == '0);
        ovf      = sgn & (ext_a == min_val) & (ext_b == '1);
        spec_o   = zero_div | ovf;
        // R7 / R8: architectural results of the shortcut cases
        if (zero_div)
            spec_val_o = op_i[OPB_REM] ? ext_a : '1;
        else
            spec_val_o = op_i[OPB_REM] ? '0 : ext_a;
    end
endmodule

// File: rtl/div_core.sv
// Unsigned restoring divider: one quotient bit per step.
module div_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] dvd_i,
    input  logic [XLEN-1:0] dvs_i,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic [XLEN-1:0] quo;
        logic [XLEN-1:0] rem;
        logic [XLEN-1:0] dvs;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [XLEN:0] shifted, trial;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.rem, st_q.quo[XLEN-1]};
        trial   = shifted - {1'b0, st_q.dvs};
        if (load_i) begin
            // word forms: park the dividend in the upper half so that
            // HALF steps leave the quotient in the lower half
            st_d.quo = word_i ? (dvd_i << HALF) : dvd_i;
            st_d.rem = '0;
            st_d.dvs = dvs_i;
        end else if (step_i) begin
            if (!trial[XLEN]) begin
                st_d.rem = trial[XLEN-1:0];
                st_d.quo = {st_q.quo[XLEN-2:0], 1'b1};
            end else begin
                st_d.rem = shifted[XLEN-1:0];
                st_d.quo = {st_q.quo[XLEN-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quo_o = st_q.quo;
    assign rem_o = st_q.rem;
endmodule

// File: rtl/div_fixup.sv
// Sign restoration, result selection and word sign extension.
module div_fixup #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] rem_i,
    input  logic            neg_q_i,
    input  logic            neg_r_i,
    input  logic            rem_sel_i,
    input  logic            word_i,
    input  logic            spec_i,
    input  logic [XLEN-1:0] spec_val_i,
    output logic [XLEN-1:0] res_o
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] q_s, r_s, pick;

    always_comb begin
        q_s  = neg_q_i ? (~quo_i + 1'b1) : quo_i;   // R6 quotient sign
        r_s  = neg_r_i ? (~rem_i + 1'b1) : rem_i;   // R6 remainder sign
        pick = spec_i ? spec_val_i : (rem_sel_i ? r_s : q_s);
        res_o = word_i ? {{HALF{pick[HALF-1]}}, pick[HALF-1:0]} : pick; // R9
    end
endmodule

// File: rtl/div_unit.sv
// Control: accepts starts while idle (R1, R4), counts steps (R2),
// pulses done (R3).
module div_unit
    import div_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic            spec;
        logic            word;
        logic            rem_sel;
        logic            neg_q;
        logic            neg_r;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] spec_val;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [XLEN-1:0] mag_a, mag_b, spec_val, quo, rem;
    logic            neg_q, neg_r, spec, accept;

    div_prep #(.XLEN(XLEN)) u_prep (
        .op_i      (op_i),
        .word_i    (word_i),
        .dvd_i     (dividend_i),
        .dvs_i     (divisor_i),
        .mag_a_o   (mag_a),
        .mag_b_o   (mag_b),
        .neg_q_o   (neg_q),
        .neg_r_o   (neg_r),
        .spec_o    (spec),
        .spec_val_o(spec_val)
    );

    assign accept = start_i & ~st_q.busy;

    div_core #(.XLEN(XLEN)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(accept & ~spec),
        .step_i(st_q.busy),
        .word_i(word_i),
        .dvd_i (mag_a),
        .dvs_i (mag_b),
        .quo_o (quo),
        .rem_o (rem)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.word     = word_i;
            st_d.rem_sel  = op_i[OPB_REM];
            st_d.neg_q    = neg_q;
            st_d.neg_r    = neg_r;
            st_d.spec     = spec;
            st_d.spec_val = spec_val;
            if (spec) begin
                st_d.done = 1'b1;
                st_d.busy = 1'b0;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = word_i ? CW'(HALF - 1) : CW'(XLEN - 1);
            end
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    div_fixup #(.XLEN(XLEN)) u_fix (
        .quo_i     (quo),
        .rem_i     (rem),
        .neg_q_i   (st_q.neg_q),
        .neg_r_i   (st_q.neg_r),
        .rem_sel_i (st_q.rem_sel),
        .word_i    (st_q.word),
        .spec_i    (st_q.spec),
        .spec_val_i(st_q.spec_val),
        .res_o     (result_o)
    );

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o,
    input logic            word_q
);
    localparam int HALF = XLEN / 2;
    localparam int LW   = $clog2(XLEN + 2) + 1;

    logic [LW-1:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lat <= '0;
        else if (start_i && !busy_o) lat <= LW'(1);
        else if (busy_o)             lat <= lat + 1'b1;
    end

    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat == LW'(1) || lat == LW'(HALF + 1) || lat == LW'(XLEN + 1)));

    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_busy_runs_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o ^ done_o));

    assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && !$past(start_i)) |-> $stable(result_o));

    assert_word_sext_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && word_q) |-> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));
endmodule

bind div_unit div_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .result_o(result_o),
    .word_q  (st_q.word)
);

// File: tb/sim_div_unit.sv
`timescale 1ns/1ps
module sim_div_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        word = 1'b0;
    logic [63:0] dvd = '0;
    logic [63:0] dvs = '0;
    logic        busy, done;
    logic [63:0] res;

    always #4 clk = ~clk;   // 125 MHz

    div_unit #(.XLEN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .word_i(word),
        .dividend_i(dvd), .divisor_i(dvs),
        .busy_o(busy), .done_o(done), .result_o(res)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- reference arithmetic (R1 R5..R9) ----------------
    function automatic logic [63:0] ref_div(input logic [1:0] o, input logic w,
                                            input logic [63:0] a, input logic [63:0] b);
        logic        uns = o[0];
        logic        rs  = o[1];
        logic [31:0] a3 = a[31:0];
        logic [31:0] b3 = b[31:0];
        logic [31:0] q3, r3;
        int          sa, sb;
        logic [63:0] q6, r6;
        longint      la, lb;
        sa = a3; sb = b3; la = a; lb = b;
        if (w) begin
            if (b3 == 0) begin q3 = '1; r3 = a3; end
            else if (!uns && a3 == 32'h8000_0000 && b3 == 32'hFFFF_FFFF) begin q3 = a3; r3 = '0; end
            else if (uns) begin q3 = a3 / b3; r3 = a3 % b3; end
            else begin q3 = sa / sb; r3 = sa % sb; end
            if (rs) return {{32{r3[31]}}, r3};
            return {{32{q3[31]}}, q3};
        end
        if (b == 0) begin q6 = '1; r6 = a; end
        else if (!uns && a == 64'h8000_0000_0000_0000 && b == '1) begin q6 = a; r6 = '0; end
        else if (uns) begin q6 = a / b; r6 = a % b; end
        else begin q6 = la / lb; r6 = la % lb; end
        return rs ? r6 : q6;
    endfunction

    function automatic logic is_spec(input logic [1:0] o, input logic w,
                                     input logic [63:0] a, input logic [63:0] b);
        if (w) return (b[31:0] == 0) ||
                      (!o[0] && a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF);
        return (b == 0) || (!o[0] && a == 64'h8000_0000_0000_0000 && b == '1);
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic w,
                                     input logic [63:0] a, input logic [63:0] b);
        if ((w && b[31:0] == 0) || (!w && b == 0)) return "R7";
        if (is_spec(o, w, a, b)) return "R8";
        if (w) return "R1 R9";
        return o[0] ? "R1 R5" : "R1 R6";
    endfunction

    // ---------------- cycle model ----------------
    logic        m_busy = 1'b0, m_done = 1'b0, m_have = 1'b0;
    int          m_cnt = 0;
    logic [63:0] m_pend = '0, m_res = '0;
    string       m_tag = "", m_pend_tag = "";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_have <= 1'b0;
        end else begin
            m_done <= 1'b0;
            if (start && !m_busy) begin
                if (is_spec(op, word, dvd, dvs)) begin
                    m_done <= 1'b1; m_have <= 1'b1;
                    m_res  <= ref_div(op, word, dvd, dvs);
                    m_tag  <= tag_of(op, word, dvd, dvs);
                end else begin
                    m_busy     <= 1'b1;
                    m_cnt      <= word ? 32 : 64;
                    m_pend     <= ref_div(op, word, dvd, dvs);
                    m_pend_tag <= tag_of(op, word, dvd, dvs);
                end
            end else if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy <= 1'b0; m_done <= 1'b1; m_have <= 1'b1;
                    m_res <= m_pend; m_tag <= m_pend_tag;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R4 busy", {63'b0, busy}, {63'b0, m_busy});
            chk({"R2 R3 done ", m_tag}, {63'b0, done}, {63'b0, m_done});
            if (m_have && !m_busy)
                chk({"R3 result ", m_tag}, res, m_res);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2 timeout actual done=0 expected done=1");
        end
    endtask

    task automatic do_op(input logic [1:0] o, input logic w,
                         input logic [63:0] a, input logic [63:0] b);
        start = 1'b1; op = o; word = w; dvd = a; dvs = b;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", {63'b0, busy}, 64'd0);
        chk("R10 done in reset", {63'b0, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy after reset", {63'b0, busy}, 64'd0);
        chk("R10 done after reset", {63'b0, done}, 64'd0);

        // R5 unsigned
        do_op(2'b01, 1'b0, 64'd100, 64'd7);
        do_op(2'b11, 1'b0, 64'd100, 64'd7);
        do_op(2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
        do_op(2'b11, 1'b0, 64'd5, 64'hFFFF_FFFF_FFFF_FFF0);
        // R6 signed, every sign pairing
        do_op(2'b00, 1'b0, -64'sd100, 64'd7);
        do_op(2'b10, 1'b0, -64'sd100, 64'd7);
        do_op(2'b00, 1'b0, 64'd100, -64'sd7);
        do_op(2'b10, 1'b0, 64'd100, -64'sd7);
        do_op(2'b00, 1'b0, -64'sd100, -64'sd7);
        do_op(2'b10, 1'b0, -64'sd100, -64'sd7);
        do_op(2'b00, 1'b0, 64'h8000_0000_0000_0000, 64'd1);
        // R7 zero divisor, all forms
        do_op(2'b00, 1'b0, 64'd1234, 64'd0);
        do_op(2'b10, 1'b0, -64'sd1234, 64'd0);
        do_op(2'b01, 1'b0, 64'd99, 64'd0);
        do_op(2'b11, 1'b1, 64'hAAAA_0000_8765_4321, 64'h1234_5678_0000_0000);
        do_op(2'b00, 1'b1, 64'd7, 64'hFFFF_FFFF_0000_0000);
        // R8 overflow, both widths
        do_op(2'b00, 1'b0, 64'h8000_0000_0000_0000, '1);
        do_op(2'b10, 1'b0, 64'h8000_0000_0000_0000, '1);
        do_op(2'b00, 1'b1, 64'h1234_5678_8000_0000, 64'h0000_0000_FFFF_FFFF);
        do_op(2'b10, 1'b1, 64'h0000_0000_8000_0000, 64'hABCD_0000_FFFF_FFFF);
        // unsigned forms do not take the overflow shortcut
        do_op(2'b01, 1'b0, 64'h8000_0000_0000_0000, '1);
        // R9 word forms with junk in the upper halves
        do_op(2'b00, 1'b1, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1111_1111_0000_0007);
        do_op(2'b10, 1'b1, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1111_1111_0000_0007);
        do_op(2'b01, 1'b1, 64'h0123_4567_FFFF_FFFF, 64'h89AB_CDEF_0000_0001);
        do_op(2'b11, 1'b1, 64'h0000_0000_F000_0000, 64'h0000_0000_7000_0000);

        // R4: start pulse mid-operation must be dropped
        start = 1'b1; op = 2'b01; word = 1'b0; dvd = 64'd1000; dvs = 64'd9;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; op = 2'b00; word = 1'b1; dvd = 64'd1; dvs = 64'd0;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R4 ignored start", res, 64'd111);

        // pseudo-random mix, back to back
        for (int i = 0; i < 40; i++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            b = (i % 3 == 0) ? {32'h0, $urandom()} :
                (i % 3 == 1) ? {$urandom(), $urandom()} : 64'(($urandom() % 50) + 1);
            if (i % 5 == 0) a = -a;
            do_op(2'(i % 4), i[1], a, b);
        end

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R2 actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule